// File: doc/BRIEF.md
# Iterative AES-128 Inverse Cipher Core

This block turns one 128-bit AES-128 ciphertext block back into its plaintext. It runs one inverse round per clock cycle in a single shared round datapath. The eleven round keys are not stored or generated inside the block. The core drives an index to an external key store and takes that store's 128-bit word back in the same cycle. It asks for key 10 first and key 0 last.

A single-cycle `start` captures `ct_in`. Eleven clock edges later, `pt_out` carries the plaintext and `done` is high for exactly one cycle. The result stays on `pt_out` until the next block completes. While a block is in flight, further `start` pulses are ignored.

Each inverse round works in this order: key XOR, inverse column mix, inverse row rotation, inverse byte substitution. The column mix is left out of the first step, the one that uses key 10. After the substitution of the last round, a plain XOR with key 0 ends the block. The state byte order follows the standard convention: byte i occupies bits 127-8i down to 120-8i, and bytes are filled column by column, so byte 4c+r is row r of column c.

Top module: `aes_dec_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` is 0 and `pt_out` is all zeros.
- R2: A `start` seen while idle makes `rk_idx` read 10 in the next cycle. It then drops by exactly one per cycle down to 0, one index per clock.
- R3: `done` is high for exactly one cycle, after the 11th rising edge that follows the edge which accepted `start`. It is low during every cycle in which `rk_idx` is stepping.
- R4: With the round keys of key 000102030405060708090a0b0c0d0e0f, ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a decrypts to 00112233445566778899aabbccddeeff. Byte 0 is bits 127:120.
- R5: For any key and block, decrypting the AES-128 encryption of a plaintext gives that plaintext back. This exercises the inverse column mix with coefficients 0e, 0b, 0d, 09, the right rotation of row r by r bytes, and the inverse substitution table.
- R6: A `start` pulse, with a different `ct_in`, that arrives while a block is in flight changes neither that block's result nor its `rk_idx` sequence nor its `done` timing.
- R7: `pt_out` changes only on the edge that completes a block. It holds while the core is idle, even if `ct_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept `ct_in` and begin a block (ignored while busy) |
| ct_in | input | 128 | Ciphertext block, byte 0 in bits 127:120 |
| rk_idx | output | 4 | Index of the round key wanted this cycle |
| rk_data | input | 128 | Round key selected by `rk_idx`, valid in the same cycle |
| pt_out | output | 128 | Recovered plaintext, held until the next completion |
| done | output | 1 | One-cycle pulse when `pt_out` is new |

## Verification
The assertions take for granted that the key store answers `rk_idx` within the same cycle, combinationally. They also take for granted that `start` is a clean synchronous level and that the key store is not rewritten while a block is in flight.

The bench models the store as an array indexed directly by `rk_idx`. It loads the array only between blocks, after `done`. It drives `start` and `ct_in` on falling edges only.

Expected plaintexts come from an AES-128 encryption and key schedule written separately in the bench. That code uses a generic field multiply and a brute-force field inverse.

// File: rtl/aes_dec_pkg.sv
`timescale 1ns/1ps
package aes_dec_pkg;
    localparam int BLK_W    = 128;
    localparam int BYTES    = BLK_W / 8;
    localparam int ROWS     = 4;
    localparam int COLS     = BYTES / ROWS;
    localparam int ROUNDS   = 10;
    localparam int RK_IDX_W = $clog2(ROUNDS + 1);

    typedef logic [7:0] byte_t;
    typedef byte_t byte_arr_t [BYTES];
    typedef byte_t tab_t [256];
    typedef enum logic {PH_IDLE, PH_RUN} phase_e;

    // doubling in GF(2^8) with the AES reduction polynomial
    function automatic byte_t xt(byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t mul9(byte_t b);
        byte_t b2, b4, b8;
        b2 = xt(b); b4 = xt(b2); b8 = xt(b4);
        return b8 ^ b;
    endfunction

    function automatic byte_t mulb(byte_t b);
        byte_t b2, b4, b8;
        b2 = xt(b); b4 = xt(b2); b8 = xt(b4);
        return b8 ^ b2 ^ b;
    endfunction

    function automatic byte_t muld(byte_t b);
        byte_t b2, b4, b8;
        b2 = xt(b); b4 = xt(b2); b8 = xt(b4);
        return b8 ^ b4 ^ b;
    endfunction

    function automatic byte_t mule(byte_t b);
        byte_t b2, b4, b8;
        b2 = xt(b); b4 = xt(b2); b8 = xt(b4);
        return b8 ^ b4 ^ b2;
    endfunction

    // general multiply, used only to build the constant table
    function automatic byte_t gmul(byte_t a, byte_t b);
        byte_t p, x;
        p = 8'h00; x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = xt(x);
        end
        return p;
    endfunction

    function automatic byte_t rotl8(byte_t v, int n);
        logic [15:0] d;
        d = {v, v} << n;
        return d[15:8];
    endfunction

    // forward substitution: x^254 followed by the affine map
    function automatic byte_t fwd_sub(byte_t x);
        byte_t r, base;
        r = 8'h01; base = x;
        for (int i = 0; i < 8; i++) begin
            if (((254 >> i) & 1) == 1) r = gmul(r, base);
            base = gmul(base, base);
        end
        return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
    endfunction

    function automatic tab_t build_inv_tab();
        tab_t t;
        for (int i = 0; i < 256; i++) t[fwd_sub(byte_t'(i))] = byte_t'(i);
        return t;
    endfunction

    function automatic byte_arr_t to_bytes(logic [BLK_W-1:0] v);
        byte_arr_t a;
        for (int i = 0; i < BYTES; i++) a[i] = v[BLK_W-1-8*i -: 8];
        return a;
    endfunction
endpackage

// File: rtl/aes_inv_round.sv
`timescale 1ns/1ps
module aes_inv_round
    import aes_dec_pkg::*;
(
    input  logic [BLK_W-1:0] blk_in,
    input  logic [BLK_W-1:0] rk,
    input  logic             skip_mix,
    output logic [BLK_W-1:0] blk_out
);
    localparam tab_t INV_TAB = build_inv_tab();

    byte_arr_t keyed, mixed, shifted;

    always_comb begin
        keyed = to_bytes(blk_in ^ rk);
        for (int c = 0; c < COLS; c++) begin
            if (skip_mix) begin
                for (int r = 0; r < ROWS; r++) mixed[4*c+r] = keyed[4*c+r];
            end else begin
                mixed[4*c+0] = mule(keyed[4*c]) ^ mulb(keyed[4*c+1]) ^ muld(keyed[4*c+2]) ^ mul9(keyed[4*c+3]);
                mixed[4*c+1] = mul9(keyed[4*c]) ^ mule(keyed[4*c+1]) ^ mulb(keyed[4*c+2]) ^ muld(keyed[4*c+3]);
                mixed[4*c+2] = muld(keyed[4*c]) ^ mul9(keyed[4*c+1]) ^ mule(keyed[4*c+2]) ^ mulb(keyed[4*c+3]);
                mixed[4*c+3] = mulb(keyed[4*c]) ^ muld(keyed[4*c+1]) ^ mul9(keyed[4*c+2]) ^ mule(keyed[4*c+3]);
            end
        end
        // row r moves right by r positions
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                shifted[4*c+r] = mixed[4*((c - r + COLS) % COLS) + r];
    end

    for (genvar i = 0; i < BYTES; i++) begin : g_sub
        assign blk_out[BLK_W-1-8*i -: 8] = INV_TAB[shifted[i]];
    end
endmodule

// File: rtl/aes_dec_ctrl.sv
`timescale 1ns/1ps
module aes_dec_ctrl
    import aes_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                busy,
    output logic [RK_IDX_W-1:0] rnd,
    output logic                first,
    output logic                last,
    output logic                done
);
    phase_e              ph;
    logic [RK_IDX_W-1:0] cnt;
    logic                done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    ph  <= PH_RUN;
                    cnt <= RK_IDX_W'(ROUNDS);
                end
                PH_RUN: if (cnt == '0) begin
                    ph     <= PH_IDLE;
                    done_q <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy  = (ph == PH_RUN);
    assign rnd   = cnt;
    assign first = busy && (cnt == RK_IDX_W'(ROUNDS));
    assign last  = busy && (cnt == '0);
    assign done  = done_q;

    assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && rnd == RK_IDX_W'(ROUNDS)));
    assert_descend_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && rnd != '0) |=> (busy && rnd == RK_IDX_W'($past(rnd) - 1'b1)));
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_cause_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(last));
    assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && rnd != '0) |=> busy);
endmodule

// File: rtl/aes_dec_core.sv
`timescale 1ns/1ps
module aes_dec_core
    import aes_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [BLK_W-1:0]    ct_in,
    output logic [RK_IDX_W-1:0] rk_idx,
    input  logic [BLK_W-1:0]    rk_data,
    output logic [BLK_W-1:0]    pt_out,
    output logic                done
);
    logic             busy, first, last;
    logic [BLK_W-1:0] state_q, round_out, pt_q;

    aes_dec_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .rnd   (rk_idx),
        .first (first),
        .last  (last),
        .done  (done)
    );

    aes_inv_round u_round (
        .blk_in   (state_q),
        .rk       (rk_data),
        .skip_mix (first),
        .blk_out  (round_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            pt_q    <= '0;
        end else begin
            if (!busy && start)     state_q <= ct_in;
            else if (busy && !last) state_q <= round_out;
            if (last)               pt_q <= state_q ^ rk_data;
        end
    end

    assign pt_out = pt_q;

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(pt_out));
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        rk_idx <= RK_IDX_W'(ROUNDS));
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> !done);
endmodule

// File: tb/aes_dec_core_tb.sv
`timescale 1ns/1ps
module aes_dec_core_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] ct_in = '0;
    logic [3:0]   rk_idx;
    logic [127:0] rk_data;
    logic [127:0] pt_out;
    logic         done;

    int checks = 0;
    int errors = 0;

    logic [127:0] rk_mem [11];
    logic [7:0]   sb [256];

    always #10 clk = ~clk;

    assign rk_data = (rk_idx <= 4'd10) ? rk_mem[rk_idx] : '0;

    aes_dec_core u_dut (
        .clk(clk), .rst(rst), .start(start), .ct_in(ct_in),
        .rk_idx(rk_idx), .rk_data(rk_data), .pt_out(pt_out), .done(done)
    );

    task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [7:0] g_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] o;
            for (int y = 1; y < 256; y++)
                if (g_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
            sb[x] = o;
        end
    endtask

    task automatic expand_key(input logic [127:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
                t ^= {rc, 24'h0};
                rc = g_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk_mem[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] encrypt(logic [127:0] pt);
        logic [7:0]   s [16];
        logic [7:0]   n [16];
        logic [127:0] v;
        v = pt ^ rk_mem[0];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) s[i] = sb[v[127-8*i -: 8]];
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++) n[4*c+w] = s[4*((c+w)%4)+w];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    s[4*c]   = g_mul(n[4*c],8'h02) ^ g_mul(n[4*c+1],8'h03) ^ n[4*c+2] ^ n[4*c+3];
                    s[4*c+1] = n[4*c] ^ g_mul(n[4*c+1],8'h02) ^ g_mul(n[4*c+2],8'h03) ^ n[4*c+3];
                    s[4*c+2] = n[4*c] ^ n[4*c+1] ^ g_mul(n[4*c+2],8'h02) ^ g_mul(n[4*c+3],8'h03);
                    s[4*c+3] = g_mul(n[4*c],8'h03) ^ n[4*c+1] ^ n[4*c+2] ^ g_mul(n[4*c+3],8'h02);
                end
            end else begin
                for (int i = 0; i < 16; i++) s[i] = n[i];
            end
            for (int i = 0; i < 16; i++) v[127-8*i -: 8] = s[i];
            v ^= rk_mem[r];
        end
        return v;
    endfunction

    // drives one block; optional extra start mid-flight
    task automatic run_block(input logic [127:0] ct, input logic [127:0] exp, input string req, input logic poke);
        @(negedge clk);
        ct_in = ct; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= 10; k++) begin
            check(rk_idx == 4'(10 - k), "R2 rk_idx step", 128'(rk_idx), 128'(10 - k));
            check(done == 1'b0, "R3 done early", 128'(done), 128'd0);
            if (poke && k == 3) begin
                start = 1'b1; ct_in = ~ct;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (poke) check(pt_out != ~ct || k == 10, "R6 no restart", pt_out, 128'd0);
        end
        check(done == 1'b1, "R3 done pulse", 128'(done), 128'd1);
        check(pt_out == exp, req, pt_out, exp);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R3 done single", 128'(done), 128'd0);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
        finish_up();
    end

    initial begin
        build_sbox();
        for (int r = 0; r < 11; r++) rk_mem[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1 done in reset", 128'(done), 128'd0);
        check(pt_out == '0, "R1 pt in reset", pt_out, 128'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && pt_out == '0, "R1 after reset", pt_out, 128'd0);

        // R4 known vector
        expand_key(128'h000102030405060708090a0b0c0d0e0f);
        check(encrypt(128'h00112233445566778899aabbccddeeff) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
              "R4 bench model", encrypt(128'h00112233445566778899aabbccddeeff), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, "R4 vector", 1'b0);

        // R5 sweep over keys and blocks, including all-zero and all-one corners
        for (int t = 0; t < 12; t++) begin
            logic [127:0] key, pt;
            if (t == 0)      begin key = '0; pt = '0; end
            else if (t == 1) begin key = '1; pt = '1; end
            else begin
                key = {32'(t * 32'h9e3779b9), 32'(t * 32'h85ebca6b), 32'(t * 32'hc2b2ae35), 32'(t * 32'h27d4eb2f)};
                pt  = {32'(t * 32'h165667b1), 32'(~t * 32'hd3a2646c), 32'(t * 32'hfd7046c5), 32'(t * 32'hb55a4f09)};
            end
            expand_key(key);
            run_block(encrypt(pt), pt, "R5 round trip", 1'b0);
        end

        // R6 start while busy
        expand_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
        run_block(encrypt(128'h3243f6a8885a308d313198a2e0370734), 128'h3243f6a8885a308d313198a2e0370734, "R6 poke result", 1'b1);

        // R7 hold while idle with changing input
        begin
            logic [127:0] held;
            held = pt_out;
            for (int k = 0; k < 6; k++) begin
                ct_in = {4{32'(k * 32'h01010101)}};
                @(posedge clk);
                @(negedge clk);
            end
            check(pt_out == held, "R7 hold idle", pt_out, held);
            check(done == 1'b0, "R7 no done idle", 128'(done), 128'd0);
        end
        finish_up();
    end
endmodule